// File: doc/BRIEF.md
# SDRAM Command Legality Tracker

This block sits next to an SDRAM device model or on the device side of a memory interface. On every rising clock edge it decodes the chip-select, row-strobe, column-strobe and write-enable pins into a command. It keeps a state for each bank (idle, row open, read or write burst with or without auto-precharge, precharging). It also keeps one device-wide state for power-down, self-refresh and the wait after a mode register load.

Every command is checked against the current state. A command that is illegal in that state raises a one-cycle violation pulse and changes nothing. A shared burst counter shows how many beats of the current read or write burst are left. The counter follows the burst length held in the block's own copy of the mode register. The memory array and the data path are not modelled.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: After reset, every bank reads idle (0), the device state reads normal (0), `violation_o` is 0 and `burst_cnt_o` is 0. The mode copy holds CAS latency 2 and burst length 1.
- R2: Activate (pins cs,ras,cas,we = 0,0,1,1) to an idle bank makes it row-open (1) on the next cycle. Activate to any bank that is not idle is a violation and leaves the bank unchanged.
- R3: Read (0,1,0,1) or Write (0,1,0,0) to a bank that is row-open or bursting puts it in read (2) or write (3) and loads `burst_cnt_o` with the burst length. The count falls by one each cycle, and when it reaches 0 the bank returns to row-open. Read or Write to an idle bank is a violation.
- R4: Read or Write with address bit 10 set selects auto-precharge, giving states 4 (read) and 5 (write). At the end of the burst the bank goes to precharging (6). A Read or Write to any bank during an auto-precharge burst is a violation.
- R5: Precharge (0,0,1,0) hits the bank on `ba_i`, or every bank when address bit 10 is set. A row-open or non-auto-precharge bursting bank spends T_RP cycles in state 6 and then goes idle. Precharge to an idle bank has no effect and no violation. Any command to a bank in state 6, or a Precharge to an auto-precharge burst, is a violation.
- R6: Mode load (0,0,0,0) with all banks idle captures the burst length from address bits 2:0 (0,1,2,3 give 1,2,4,8; 7 gives full page) and the CAS latency from bits 6:4 (1, 2 or 3). The device then reads state 3 for T_MRD cycles. A reserved code, or any bank not idle, is a violation and the mode copy stays unchanged.
- R7: A Write while a read burst is still counting is legal only when the CAS latency is 3 and `dqm_i` was high in the cycle before. Otherwise it is a violation, so a Write following a Read needs burst length plus one cycles.
- R8: With all banks idle, a NOP with `cke_i` low enters power-down (1). The device stays there while `cke_i` is low and returns to normal after `cke_i` is sampled high on T_CKE_EXIT consecutive edges.
- R9: Auto-refresh (0,0,0,1) with all banks idle and `cke_i` high is legal and changes no state. With `cke_i` low it enters self-refresh (2), which exits like power-down with all banks idle. Refresh with any bank not idle is a violation.
- R10: In power-down, self-refresh or the mode-load wait, any command other than NOP is a violation with no effect. In normal state, `cke_i` low is a violation unless all banks are idle and the command is NOP or refresh.
- R11: With full-page length, `burst_cnt_o` loads 2^COL_W and reloads instead of ending, so the bank stays bursting. A Precharge to that bank ends the burst and clears the count.
- R12: `cs_ni` high is a NOP whatever the other pins are. The pattern 0,1,1,0 is a violation. The violation pulse appears in the cycle after the offending edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cke_i | input | 1 | Clock enable pin |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Address; bit 10 is auto-precharge / all-bank select |
| ba_i | input | BA_W | Bank select |
| dqm_i | input | 1 | Data mask pin |
| bank_state_o | output | 3*NUM_BANKS | Bank b state in bits 3b+2:3b |
| dev_state_o | output | 2 | 0 normal, 1 power-down, 2 self-refresh, 3 mode-load wait |
| violation_o | output | 1 | Registered illegal-command pulse |
| burst_cnt_o | output | COL_W+1 | Beats left in current burst |

## Verification
The bench goes after the edges of the timing windows. It issues a Write exactly at burst length after a Read and again one cycle later; an off-by-one in the counter would accept the first or reject the second. It probes a bank during the last precharge cycle, where a short timer would show it idle too early. It interrupts an auto-precharge burst from the other bank, which a design that only checked the target bank would accept. It runs a full 512-beat page to catch a counter that ends instead of wrapping. Mode loads with reserved codes follow a good load, so a design that takes them shows a wrong burst length on the next Read.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;
  typedef enum logic [2:0] {
    C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_REF, C_MRS, C_UNDEF
  } cmd_e;

  typedef enum logic [2:0] {
    B_IDLE     = 3'd0,
    B_ACTIVE   = 3'd1,
    B_READ     = 3'd2,
    B_WRITE    = 3'd3,
    B_READ_AP  = 3'd4,
    B_WRITE_AP = 3'd5,
    B_PRE      = 3'd6
  } bank_st_e;

  typedef enum logic [1:0] {
    D_NORMAL  = 2'd0,
    D_PWRDN   = 2'd1,
    D_SELFREF = 2'd2,
    D_MRS     = 2'd3
  } dev_st_e;

  localparam int AP_BIT = 10;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);
  always_comb begin
    if (cs_ni) cmd_o = C_NOP;
    else begin
      case ({ras_ni, cas_ni, we_ni})
        3'b111:  cmd_o = C_NOP;
        3'b011:  cmd_o = C_ACT;
        3'b101:  cmd_o = C_RD;
        3'b100:  cmd_o = C_WR;
        3'b010:  cmd_o = C_PRE;
        3'b001:  cmd_o = C_REF;
        3'b000:  cmd_o = C_MRS;
        default: cmd_o = C_UNDEF;
      endcase
    end
  end
endmodule

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       bl_code_i,
  input  logic [2:0]       cl_code_i,
  output logic             ok_o,
  output logic [1:0]       cl_o,
  output logic [CNT_W-1:0] bl_o,
  output logic             fp_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(1) << (CNT_W - 1);

  logic             bl_ok, cl_ok;
  logic [CNT_W-1:0] bl_d;

  assign bl_ok = (bl_code_i[2] == 1'b0) || (bl_code_i == 3'd7);
  assign cl_ok = (cl_code_i != 3'd0) && (cl_code_i[2] == 1'b0);
  assign ok_o  = bl_ok && cl_ok;
  assign bl_d  = bl_code_i[2] ? FULL : (CNT_W'(1) << bl_code_i[1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cl_o <= 2'd2;
      bl_o <= CNT_W'(1);
      fp_o <= 1'b0;
    end else if (we_i && ok_o) begin
      cl_o <= cl_code_i[1:0];
      bl_o <= bl_d;
      fp_o <= bl_code_i[2];
    end
  end

  assert_load_legal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_i && !ok_o) |-> ($stable(cl_o) && $stable(bl_o)));
endmodule

// File: rtl/sdram_burst_ctr.sv
module sdram_burst_ctr #(
  parameter int CNT_W = 10,
  parameter int BA_W  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [BA_W-1:0]  ba_i,
  input  logic             rd_i,
  input  logic             ap_i,
  input  logic             fp_i,
  input  logic [CNT_W-1:0] bl_i,
  input  logic             stop_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             busy_o,
  output logic [BA_W-1:0]  owner_o,
  output logic             rd_o,
  output logic             ap_o,
  output logic             end_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(1) << (CNT_W - 1);

  logic fp_q;

  assign busy_o = cnt_o != '0;
  assign end_o  = (cnt_o == CNT_W'(1)) && !fp_q && !load_i && !stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o   <= '0;
      owner_o <= '0;
      rd_o    <= 1'b0;
      ap_o    <= 1'b0;
      fp_q    <= 1'b0;
    end else if (load_i) begin
      cnt_o   <= bl_i;
      owner_o <= ba_i;
      rd_o    <= rd_i;
      ap_o    <= ap_i;
      fp_q    <= fp_i;
    end else if (stop_i) begin
      cnt_o <= '0;
    end else if (busy_o) begin
      cnt_o <= (cnt_o == CNT_W'(1) && fp_q) ? FULL : cnt_o - CNT_W'(1);
    end
  end

  assert_cnt_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cnt_o) > CNT_W'(1) && !$past(load_i) && !$past(stop_i))
      |-> (cnt_o == $past(cnt_o) - CNT_W'(1)));
endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
  import sdram_trk_pkg::*;
#(
  parameter int T_RP = 3
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  cmd_e     cmd_i,
  input  logic     sel_i,
  input  logic     ap_i,
  input  logic     go_i,
  input  logic     rw_other_i,
  input  logic     burst_end_i,
  output bank_st_e state_o,
  output logic     bad_o
);
  localparam int TW = (T_RP > 1) ? $clog2(T_RP) : 1;
  localparam logic [TW-1:0] TRP_LD = TW'(T_RP - 1);

  bank_st_e      st_d;
  logic [TW-1:0] tmr_q, tmr_d;

  always_comb begin
    bad_o = 1'b0;
    if (sel_i) begin
      case (cmd_i)
        C_ACT:      bad_o = state_o != B_IDLE;
        C_RD, C_WR: bad_o = !(state_o inside {B_ACTIVE, B_READ, B_WRITE});
        C_PRE:      bad_o = state_o inside {B_READ_AP, B_WRITE_AP, B_PRE};
        default:    bad_o = 1'b0;
      endcase
    end
  end

  always_comb begin
    st_d  = state_o;
    tmr_d = tmr_q;
    if (go_i) begin
      case (cmd_i)
        C_ACT: st_d = B_ACTIVE;
        C_RD:  st_d = ap_i ? B_READ_AP : B_READ;
        C_WR:  st_d = ap_i ? B_WRITE_AP : B_WRITE;
        C_PRE: if (state_o != B_IDLE) begin
                 st_d  = B_PRE;
                 tmr_d = TRP_LD;
               end
        default: ;
      endcase
    end else if (rw_other_i && (state_o == B_READ || state_o == B_WRITE)) begin
      st_d = B_ACTIVE;
    end else if (burst_end_i) begin
      case (state_o)
        B_READ, B_WRITE: st_d = B_ACTIVE;
        B_READ_AP, B_WRITE_AP: begin
          st_d  = B_PRE;
          tmr_d = TRP_LD;
        end
        default: ;
      endcase
    end else if (state_o == B_PRE) begin
      if (tmr_q == '0) st_d = B_IDLE;
      else tmr_d = tmr_q - TW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= B_IDLE;
      tmr_q   <= '0;
    end else begin
      state_o <= st_d;
      tmr_q   <= tmr_d;
    end
  end

  assert_idle_via_pre_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == B_IDLE && $past(state_o) != B_IDLE) |-> ($past(state_o) == B_PRE));

  assert_open_from_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == B_ACTIVE && $past(state_o) == B_IDLE) |-> $past(go_i && cmd_i == C_ACT));
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS  = 2,
  parameter int ADDR_W     = 12,
  parameter int COL_W      = 9,
  parameter int T_RP       = 3,
  parameter int T_MRD      = 2,
  parameter int T_CKE_EXIT = 2,
  localparam int BA_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CNT_W     = COL_W + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cke_i,
  input  logic                   cs_ni,
  input  logic                   ras_ni,
  input  logic                   cas_ni,
  input  logic                   we_ni,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [BA_W-1:0]        ba_i,
  input  logic                   dqm_i,
  output logic [3*NUM_BANKS-1:0] bank_state_o,
  output logic [1:0]             dev_state_o,
  output logic                   violation_o,
  output logic [CNT_W-1:0]       burst_cnt_o
);
  localparam int EXW = (T_CKE_EXIT > 1) ? $clog2(T_CKE_EXIT) : 1;
  localparam int MW  = (T_MRD > 1) ? $clog2(T_MRD) : 1;

  cmd_e     cmd;
  dev_st_e  dev_q;
  bank_st_e st [NUM_BANKS];
  logic [NUM_BANKS-1:0] sel, bad, idle;
  logic       is_nop, is_rw, ap, all_idle, bank_bad, burst_bad, viol_d, accept, dqm_q;
  logic       mode_ok, fp, b_busy, b_rd, b_ap, b_end, b_stop;
  logic [1:0] cl;
  logic [CNT_W-1:0] bl;
  logic [BA_W-1:0]  b_owner;
  logic [EXW-1:0]   ex_q;
  logic [MW-1:0]    mrd_q;
  logic             unused_addr;

  // row/column bits belong to the array; burst type does not alter tracking
  assign unused_addr = ^{addr_i[ADDR_W-1:AP_BIT+1], addr_i[AP_BIT-1:7], addr_i[3]};

  sdram_cmd_decode u_dec (
    .cs_ni (cs_ni), .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni), .cmd_o(cmd)
  );

  assign is_nop = cmd == C_NOP;
  assign is_rw  = (cmd == C_RD) || (cmd == C_WR);
  assign ap     = addr_i[AP_BIT];

  sdram_mode_reg #(.CNT_W(CNT_W)) u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (accept && cmd == C_MRS),
    .bl_code_i (addr_i[2:0]),
    .cl_code_i (addr_i[6:4]),
    .ok_o      (mode_ok),
    .cl_o      (cl),
    .bl_o      (bl),
    .fp_o      (fp)
  );

  assign b_stop = accept && cmd == C_PRE && (ap || ba_i == b_owner);

  sdram_burst_ctr #(.CNT_W(CNT_W), .BA_W(BA_W)) u_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept && is_rw),
    .ba_i    (ba_i),
    .rd_i    (cmd == C_RD),
    .ap_i    (ap),
    .fp_i    (fp),
    .bl_i    (bl),
    .stop_i  (b_stop),
    .cnt_o   (burst_cnt_o),
    .busy_o  (b_busy),
    .owner_o (b_owner),
    .rd_o    (b_rd),
    .ap_o    (b_ap),
    .end_o   (b_end)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign sel[b]  = (cmd == C_PRE && ap) || (ba_i == BA_W'(b));
    assign idle[b] = st[b] == B_IDLE;

    sdram_bank_fsm #(.T_RP(T_RP)) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cmd_i       (cmd),
      .sel_i       (sel[b]),
      .ap_i        (ap),
      .go_i        (accept && sel[b]),
      .rw_other_i  (accept && is_rw && !sel[b]),
      .burst_end_i (b_end && b_owner == BA_W'(b)),
      .state_o     (st[b]),
      .bad_o       (bad[b])
    );

    assign bank_state_o[3*b +: 3] = st[b];
  end

  assign all_idle  = &idle;
  assign bank_bad  = |bad;
  // an auto-precharge burst cannot be cut; write over read needs CL3 and prior mask
  assign burst_bad = is_rw && b_busy &&
                     (b_ap || (cmd == C_WR && b_rd && !(cl == 2'd3 && dqm_q)));

  always_comb begin
    if (dev_q != D_NORMAL) viol_d = !is_nop;
    else viol_d = (cmd == C_UNDEF) || bank_bad || burst_bad
               || ((cmd == C_REF || cmd == C_MRS) && !all_idle)
               || (cmd == C_MRS && !mode_ok)
               || (!cke_i && !(all_idle && (is_nop || cmd == C_REF)));
  end

  assign accept = (dev_q == D_NORMAL) && !is_nop && !viol_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dev_q       <= D_NORMAL;
      ex_q        <= '0;
      mrd_q       <= '0;
      dqm_q       <= 1'b0;
      violation_o <= 1'b0;
    end else begin
      dqm_q       <= dqm_i;
      violation_o <= viol_d;
      case (dev_q)
        D_NORMAL: begin
          if (!cke_i && all_idle && is_nop) dev_q <= D_PWRDN;
          else if (accept && cmd == C_REF && !cke_i) dev_q <= D_SELFREF;
          else if (accept && cmd == C_MRS) begin
            dev_q <= D_MRS;
            mrd_q <= MW'(T_MRD - 1);
          end
          ex_q <= '0;
        end
        D_PWRDN, D_SELFREF: begin
          if (!cke_i) ex_q <= '0;
          else if (ex_q == EXW'(T_CKE_EXIT - 1)) begin
            dev_q <= D_NORMAL;
            ex_q  <= '0;
          end else ex_q <= ex_q + EXW'(1);
        end
        D_MRS: begin
          if (mrd_q == '0) dev_q <= D_NORMAL;
          else mrd_q <= mrd_q - MW'(1);
        end
        default: dev_q <= D_NORMAL;
      endcase
    end
  end

  assign dev_state_o = dev_q;

  assert_pd_entry_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_q == D_PWRDN && $past(dev_q) == D_NORMAL) |-> $past(all_idle && !cke_i));

  assert_lp_exit_cke_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_q == D_NORMAL && ($past(dev_q) == D_PWRDN || $past(dev_q) == D_SELFREF))
      |-> $past(cke_i));

  assert_sr_entry_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_q == D_SELFREF && $past(dev_q) == D_NORMAL) |-> $past(all_idle && cmd == C_REF));

  assert_lp_no_burst_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_q == D_PWRDN || dev_q == D_SELFREF) |-> (all_idle && !b_busy));
endmodule

// File: tb/sim_sdram_cmd_tracker.sv
module sim_sdram_cmd_tracker;
  localparam logic [3:0] P_NOP = 4'b0111, P_ACT = 4'b0011, P_RD  = 4'b0101,
                         P_WR  = 4'b0100, P_PRE = 4'b0010, P_REF = 4'b0001,
                         P_MRS = 4'b0000, P_BST = 4'b0110;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [11:0] addr = '0;
  logic        ba = 1'b0, dqm = 1'b0;
  logic [5:0]  bst;
  logic [1:0]  dst;
  logic        viol;
  logic [9:0]  bcnt;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  sdram_cmd_tracker u0 (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .addr_i(addr), .ba_i(ba), .dqm_i(dqm),
    .bank_state_o(bst), .dev_state_o(dst), .violation_o(viol), .burst_cnt_o(bcnt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic k, input logic [3:0] p, input logic [11:0] a,
                      input logic b, input logic m);
    cke = k; {cs_n, ras_n, cas_n, we_n} = p; addr = a; ba = b; dqm = m;
    @(posedge clk); #1;
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) step(1'b1, P_NOP, 12'h000, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; repeat (3) @(posedge clk); #1; rst_n = 1'b1; nop(1);
    chk("R1 bank0", bst[2:0], 0); chk("R1 bank1", bst[5:3], 0);
    chk("R1 dev", dst, 0); chk("R1 viol", viol, 0); chk("R1 cnt", bcnt, 0);
  endtask

  task automatic t_mode;
    step(1, P_MRS, 12'h032, 0, 0);  // BL4, CL3
    chk("R6 dev wait", dst, 3); chk("R6 viol", viol, 0);
    step(1, P_ACT, 12'h000, 0, 0);
    chk("R10 act in mrs viol", viol, 1); chk("R10 bank kept", bst[2:0], 0);
    nop(1); chk("R6 dev back", dst, 0);
    step(1, P_MRS, 12'h005, 0, 0);  // reserved codes
    chk("R6 reserved viol", viol, 1); chk("R6 reserved dev", dst, 0);
  endtask

  task automatic t_act_read;
    step(1, P_ACT, 12'h000, 0, 0);
    chk("R2 open", bst[2:0], 1); chk("R2 viol", viol, 0);
    step(1, P_ACT, 12'h000, 0, 0);
    chk("R2 double act viol", viol, 1); chk("R2 kept", bst[2:0], 1);
    step(1, P_RD, 12'h000, 1, 0);
    chk("R3 rd idle viol", viol, 1); chk("R3 bank1 idle", bst[5:3], 0);
    step(1, P_RD, 12'h000, 0, 0);
    chk("R3 read st", bst[2:0], 2); chk("R3 R6 cnt bl4", bcnt, 4);
    for (int i = 3; i >= 1; i--) begin
      nop(1); chk("R3 cnt down", bcnt, i); chk("R3 still read", bst[2:0], 2);
    end
    nop(1); chk("R3 cnt end", bcnt, 0); chk("R3 back open", bst[2:0], 1);
  endtask

  task automatic t_wr_over_rd_cl3;
    step(1, P_RD, 12'h000, 0, 1);
    step(1, P_WR, 12'h000, 0, 1);
    chk("R7 cl3 viol", viol, 0); chk("R7 cl3 write", bst[2:0], 3); chk("R7 cnt", bcnt, 4);
    step(1, P_NOP, 12'h000, 0, 0); nop(3);
    chk("R3 write done", bst[2:0], 1);
    step(1, P_PRE, 12'h000, 1, 0);
    chk("R5 pre idle viol", viol, 0); chk("R5 pre idle st", bst[5:3], 0);
    step(1, P_PRE, 12'h400, 0, 0);
    chk("R5 pre all", bst[2:0], 6); chk("R5 pre all idle b1", bst[5:3], 0);
    step(1, P_ACT, 12'h000, 0, 0);
    chk("R5 act in pre viol", viol, 1); chk("R5 still pre", bst[2:0], 6);
    nop(1); chk("R5 last pre cycle", bst[2:0], 6);
    nop(1); chk("R5 idle after trp", bst[2:0], 0);
  endtask

  task automatic t_wr_over_rd_cl2;
    step(1, P_MRS, 12'h022, 0, 0); nop(2);
    step(1, P_ACT, 12'h000, 0, 0);
    step(1, P_RD, 12'h000, 0, 1);
    step(1, P_WR, 12'h000, 0, 1);
    chk("R7 cl2 viol", viol, 1); chk("R7 still read", bst[2:0], 2);
    nop(2);
    step(1, P_WR, 12'h000, 0, 1);
    chk("R7 at bl viol", viol, 1); chk("R7 open after bl", bst[2:0], 1);
    step(1, P_WR, 12'h000, 0, 0);
    chk("R7 bl+1 ok", viol, 0); chk("R7 write st", bst[2:0], 3);
    nop(4); chk("R3 wr end", bst[2:0], 1);
  endtask

  task automatic t_autopre;
    step(1, P_ACT, 12'h000, 1, 0);
    step(1, P_RD, 12'h400, 0, 0);
    chk("R4 read ap", bst[2:0], 4);
    step(1, P_RD, 12'h000, 1, 0);
    chk("R4 interrupt viol", viol, 1); chk("R4 b1 kept", bst[5:3], 1);
    chk("R4 still ap", bst[2:0], 4);
    nop(2); chk("R4 last beat", bst[2:0], 4);
    nop(1); chk("R4 to pre", bst[2:0], 6); chk("R4 cnt 0", bcnt, 0);
    nop(2); chk("R4 pre hold", bst[2:0], 6);
    nop(1); chk("R4 idle", bst[2:0], 0);
    step(1, P_PRE, 12'h000, 1, 0); nop(3);
    chk("R5 b1 idle", bst[5:3], 0);
  endtask

  task automatic t_powerdown;
    step(0, P_NOP, 12'h000, 0, 0);
    chk("R8 pd entry", dst, 1); chk("R8 viol", viol, 0);
    step(0, P_NOP, 12'h000, 0, 0); chk("R8 pd hold", dst, 1);
    step(0, P_ACT, 12'h000, 0, 0);
    chk("R10 act in pd viol", viol, 1); chk("R10 pd bank", bst[2:0], 0);
    step(1, P_NOP, 12'h000, 0, 0); chk("R8 one high edge", dst, 1);
    step(1, P_NOP, 12'h000, 0, 0); chk("R8 exit", dst, 0);
  endtask

  task automatic t_selfref;
    step(1, P_REF, 12'h000, 0, 0);
    chk("R9 ref viol", viol, 0); chk("R9 ref dev", dst, 0);
    step(0, P_REF, 12'h000, 0, 0); chk("R9 sr entry", dst, 2);
    step(0, P_NOP, 12'h000, 0, 0); chk("R9 sr hold", dst, 2);
    step(1, P_NOP, 12'h000, 0, 0); chk("R9 sr one edge", dst, 2);
    step(1, P_NOP, 12'h000, 0, 0);
    chk("R9 sr exit", dst, 0); chk("R9 banks idle", bst, 0);
  endtask

  task automatic t_busy_cke;
    step(1, P_ACT, 12'h000, 0, 0);
    step(1, P_REF, 12'h000, 0, 0); chk("R9 ref busy viol", viol, 1);
    step(0, P_NOP, 12'h000, 0, 0);
    chk("R10 cke low busy viol", viol, 1); chk("R10 no pd", dst, 0);
    step(1, P_PRE, 12'h000, 0, 0); nop(3);
    chk("R5 idle again", bst[2:0], 0);
  endtask

  task automatic t_cs;
    step(1, 4'b1000, 12'h000, 0, 0);
    chk("R12 cs high no viol", viol, 0); chk("R12 cs high no act", bst[2:0], 0);
    step(1, P_BST, 12'h000, 0, 0);
    chk("R12 undefined viol", viol, 1); chk("R12 undefined st", bst[2:0], 0);
    nop(1); chk("R12 pulse one cycle", viol, 0);
  endtask

  task automatic t_fullpage;
    step(1, P_MRS, 12'h037, 0, 0); nop(2);
    step(1, P_ACT, 12'h000, 0, 0);
    step(1, P_RD, 12'h000, 0, 0);
    chk("R11 load", bcnt, 512);
    nop(511); chk("R11 last", bcnt, 1); chk("R11 reading", bst[2:0], 2);
    nop(1); chk("R11 wrap", bcnt, 512); chk("R11 stays read", bst[2:0], 2);
    step(1, P_PRE, 12'h000, 0, 0);
    chk("R11 pre stop", bst[2:0], 6); chk("R11 cnt clear", bcnt, 0);
    nop(3); chk("R11 idle", bst[2:0], 0);
  endtask

  initial begin
    #(5 * 150000);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset;
    t_mode;
    t_act_read;
    t_wr_over_rd_cl3;
    t_wr_over_rd_cl2;
    t_autopre;
    t_powerdown;
    t_selfref;
    t_busy_cke;
    t_cs;
    t_fullpage;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule